// File: doc/BRIEF.md
# Four-Channel Input-Capture Timer

This block keeps a 16-bit up-counter that runs all the time. A power-of-two prescaler paces the counter. The block watches four input pins. When a pin shows one of the edges chosen for its channel, the channel stores the counter value in its own capture register, raises its flag, and can raise the shared interrupt line. Software sets the block up and reads it back through a simple word-wide register port. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

A channel can capture only when two settings agree. Its mode bit must select input capture, and its direction bit must mark the pin as an input. Choosing capture mode does not change the direction bit. Each pin passes through a two-flop synchroniser before the edge detector. A pin level therefore has to stay put for more than two module clocks before it is seen. The capture register takes the counter value that is present two clocks after the pin change is first registered.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, these all read 0: the counter (address 6), the four capture registers (addresses 8 to 11), the flag register (address 4), the interrupt-enable register (address 5), the mode register (address 1) and the direction register (address 3). The interrupt output is low after reset.
- R2: Bits [2:0] of address 0 hold PR. The counter steps once every 2^PR module clocks. A write to address 0 restarts the divider, so the first step comes 2^PR clocks after the write edge.
- R3: The counter steps by exactly one and wraps from 0xFFFF to 0x0000.
- R4: Suppose a capturing channel's pin changes before clock edge k, and the change is an active edge. At edge k+2 that channel's capture register (address 8+n) takes the counter value that was present just before edge k+2.
- R5: Address 2 holds the edge-select field. Channel n uses bits [2n+1:2n], with 00 = off, 01 = rising edge, 10 = falling edge and 11 = both edges. An edge that is not selected leaves the capture register and the flag unchanged.
- R6: Bit n of address 1 set to 1 takes channel n out of input-capture mode. An active edge then changes neither the capture register nor the flag.
- R7: Bit n of address 3 set to 1 marks pin n as an output. An active edge then changes neither the capture register nor the flag.
- R8: A capture sets flag bit n of address 4. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: If a capture and a write-1 clear hit the same flag in the same cycle, the flag stays set and the capture register still updates.
- R10: The interrupt output is high exactly when some flag bit n and interrupt-enable bit n (address 5) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| pinIn | input | 4 | Channel input pins |
| irqOut | output | 1 | Interrupt request |

## Verification
A flag can be set by a capture and cleared by a software write in the same clock. The bench first gives channel 0 a captured flag. It then raises the channel's pin three falling clock edges before a write-1 clear of that flag, so the capture and the clear land on the same rising edge. The scoreboard expects the flag still set and the capture register holding the counter value predicted from a counter read taken when the pin was driven.

// File: rtl/capt_timer_pkg.sv
`timescale 1ns/1ps
package capt_timer_pkg;
  localparam int CH_NUM  = 4;
  localparam int CNT_W   = 16;
  localparam int PR_W    = 3;
  localparam int DIV_W   = (1 << PR_W) - 1;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int EDGE_W  = 2 * CH_NUM;

  localparam int ADDR_PRE  = 0;
  localparam int ADDR_MODE = 1;
  localparam int ADDR_EDGE = 2;
  localparam int ADDR_DIR  = 3;
  localparam int ADDR_FLAG = 4;
  localparam int ADDR_IEN  = 5;
  localparam int ADDR_CNT  = 6;
  localparam int ADDR_CAP0 = 8;

  typedef struct packed {
    logic              prRestart;
    logic [PR_W-1:0]   prSel;
    logic [CH_NUM-1:0] armMask;
    logic [CH_NUM-1:0] riseEn;
    logic [CH_NUM-1:0] fallEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/capt_timer_ctrl.sv
`timescale 1ns/1ps
module capt_timer_ctrl
  import capt_timer_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic                           regWrEn,
  input  logic [DATA_W-1:0]              regWrData,
  output logic [DATA_W-1:0]              regRdData,
  input  logic [CH_NUM-1:0]              hitVec,
  input  logic [CNT_W-1:0]               counterVal,
  input  logic [CH_NUM-1:0][CNT_W-1:0]   capVal,
  output ctrlStrobes_t                   strobes,
  output logic [CH_NUM-1:0]              flagVec,
  output logic                           irqOut
);
  logic [PR_W-1:0]   prSelQ;
  logic [CH_NUM-1:0] modeQ;
  logic [EDGE_W-1:0] edgeSelQ;
  logic [CH_NUM-1:0] dirQ;
  logic [CH_NUM-1:0] flagQ;
  logic [CH_NUM-1:0] irqEnQ;
  logic [CH_NUM-1:0] clrMask;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:EDGE_W];

  function automatic logic isWr(input logic [ADDR_W-1:0] a, input int target);
    return regWrEn && (a == ADDR_W'(target));
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prSelQ   <= '0;
      modeQ    <= '0;
      edgeSelQ <= '0;
      dirQ     <= '0;
      irqEnQ   <= '0;
    end else begin
      if (isWr(regAddr, ADDR_PRE))  prSelQ   <= regWrData[PR_W-1:0];
      if (isWr(regAddr, ADDR_MODE)) modeQ    <= regWrData[CH_NUM-1:0];
      if (isWr(regAddr, ADDR_EDGE)) edgeSelQ <= regWrData[EDGE_W-1:0];
      if (isWr(regAddr, ADDR_DIR))  dirQ     <= regWrData[CH_NUM-1:0];
      if (isWr(regAddr, ADDR_IEN))  irqEnQ   <= regWrData[CH_NUM-1:0];
    end
  end

  // Write-one-to-clear; a capture in the same cycle takes precedence.
  always_comb begin
    clrMask = isWr(regAddr, ADDR_FLAG) ? regWrData[CH_NUM-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | hitVec;
  end

  always_comb begin
    strobes.prRestart = isWr(regAddr, ADDR_PRE);
    strobes.prSel     = prSelQ;
    for (int i = 0; i < CH_NUM; i++) begin
      strobes.armMask[i] = !modeQ[i] && !dirQ[i];
      strobes.riseEn[i]  = edgeSelQ[2*i];
      strobes.fallEn[i]  = edgeSelQ[2*i+1];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_PRE):  regRdData = DATA_W'(prSelQ);
      ADDR_W'(ADDR_MODE): regRdData = DATA_W'(modeQ);
      ADDR_W'(ADDR_EDGE): regRdData = DATA_W'(edgeSelQ);
      ADDR_W'(ADDR_DIR):  regRdData = DATA_W'(dirQ);
      ADDR_W'(ADDR_FLAG): regRdData = DATA_W'(flagQ);
      ADDR_W'(ADDR_IEN):  regRdData = DATA_W'(irqEnQ);
      ADDR_W'(ADDR_CNT):  regRdData = DATA_W'(counterVal);
      default:            regRdData = '0;
    endcase
    for (int i = 0; i < CH_NUM; i++) begin
      if (regAddr == ADDR_W'(ADDR_CAP0 + i)) regRdData = DATA_W'(capVal[i]);
    end
  end

  assign flagVec = flagQ;
  assign irqOut  = |(flagQ & irqEnQ);
endmodule

// File: rtl/capt_timer_dp.sv
`timescale 1ns/1ps
module capt_timer_dp
  import capt_timer_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [CH_NUM-1:0]            pinIn,
  output logic [CH_NUM-1:0]            hitVec,
  output logic [CNT_W-1:0]             counterVal,
  output logic [CH_NUM-1:0][CNT_W-1:0] capVal
);
  logic [DIV_W-1:0] divCntQ;
  logic [DIV_W-1:0] prMask;
  logic             tick;
  logic [CNT_W-1:0] counterQ;

  always_comb begin
    prMask = DIV_W'((32'd1 << strobes.prSel) - 32'd1);
    tick   = !strobes.prRestart && ((divCntQ & prMask) == prMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCntQ <= '0;
    else if (strobes.prRestart) divCntQ <= '0;
    else                        divCntQ <= divCntQ + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     counterQ <= '0;
    else if (tick) counterQ <= counterQ + CNT_W'(1);
  end

  assign counterVal = counterQ;

  for (genvar n = 0; n < CH_NUM; n++) begin : g_chan
    logic [1:0]       syncQ;
    logic             prevQ;
    logic             rise;
    logic             fall;
    logic             hit;
    logic [CNT_W-1:0] capQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[0], pinIn[n]};
        prevQ <= syncQ[1];
      end
    end

    always_comb begin
      rise = syncQ[1] && !prevQ;
      fall = !syncQ[1] && prevQ;
      hit  = strobes.armMask[n] &&
             ((rise && strobes.riseEn[n]) || (fall && strobes.fallEn[n]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    capQ <= '0;
      else if (hit) capQ <= counterQ;
    end

    assign hitVec[n] = hit;
    assign capVal[n] = capQ;
  end
endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
  import capt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [3:0]        pinIn,
  output logic              irqOut
);
  ctrlStrobes_t                  strobes;
  logic [CH_NUM-1:0]             hitVec;
  logic [CH_NUM-1:0]             flagVec;
  logic [CNT_W-1:0]              counterVal;
  logic [CH_NUM-1:0][CNT_W-1:0]  capVal;

  capt_timer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .hitVec(hitVec),
    .counterVal(counterVal), .capVal(capVal), .strobes(strobes),
    .flagVec(flagVec), .irqOut(irqOut)
  );

  capt_timer_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pinIn(pinIn),
    .hitVec(hitVec), .counterVal(counterVal), .capVal(capVal)
  );
endmodule

// File: rtl/capt_timer_chk.sv
`timescale 1ns/1ps
module capt_timer_chk
  import capt_timer_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [CH_NUM-1:0]            hitVec,
  input logic [CH_NUM-1:0]            flagVec,
  input logic [CNT_W-1:0]             counterVal,
  input logic [CH_NUM-1:0][CNT_W-1:0] capVal
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (counterVal == $past(counterVal)) || (counterVal == $past(counterVal) + CNT_W'(1))); // R3

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((flagVec & $past(hitVec)) == $past(hitVec))); // R9

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !hitVec[n] |=> $stable(capVal[n])); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagVec[n]) |-> $past(hitVec[n])); // R8
  end
endmodule

bind edge_capture_timer capt_timer_chk chk_i (
  .clk(clk), .rstN(rstN), .hitVec(hitVec), .flagVec(flagVec),
  .counterVal(counterVal), .capVal(capVal)
);

// File: tb/edge_capture_timer_tb_top.sv
`timescale 1ns/1ps
module edge_capture_timer_tb_top;
  import capt_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic [3:0]  pinIn;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          ch;
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  event evCheck, evDone;

  always #2.5 clk = ~clk;

  edge_capture_timer dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peek(input int a, output logic [15:0] d);
    regAddr = 4'(a);
    #0.1;
    d = regRdData;
  endtask

  task automatic wrReg(input int a, input logic [15:0] d);
    @(negedge clk);
    regAddr = 4'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Driver: drive an edge that must capture; expected value goes to the scoreboard.
  task automatic edgeOn(input int ch, input logic lvl, input string tag);
    logic [15:0] c;
    @(negedge clk);
    peek(ADDR_CNT, c);
    pinIn[ch] = lvl;
    sbQ.push_back('{ch, c + 16'd2, tag});
    repeat (3) @(negedge clk);
    ->evCheck;
    @(evDone);
  endtask

  // Drive an edge that must not capture; capture and flags must not move.
  task automatic edgeNone(input int ch, input logic lvl, input string tag);
    logic [15:0] capB, capA, flB, flA;
    @(negedge clk);
    peek(ADDR_CAP0 + ch, capB);
    peek(ADDR_FLAG, flB);
    pinIn[ch] = lvl;
    repeat (4) @(negedge clk);
    peek(ADDR_CAP0 + ch, capA);
    peek(ADDR_FLAG, flA);
    chk({tag, " capture unchanged"}, capA, capB);
    chk({tag, " flags unchanged"}, flA, flB);
  endtask

  // Monitor: pops expected captures and compares with the design.
  initial begin
    forever begin
      @(evCheck);
      #1;
      while (sbQ.size() > 0) begin
        expItem_t it;
        logic [15:0] v, f;
        it = sbQ.pop_front();
        peek(ADDR_CAP0 + it.ch, v);
        chk({it.tag, " capture value"}, v, it.val);
        peek(ADDR_FLAG, f);
        chk({it.tag, " flag set (R8)"}, {15'd0, f[it.ch]}, 16'd1);
      end
      ->evDone;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v, c;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    peek(ADDR_CNT, v);  chk("R1 counter", v, 16'h0);
    peek(ADDR_FLAG, v); chk("R1 flags", v, 16'h0);
    peek(ADDR_IEN, v);  chk("R1 irq enables", v, 16'h0);
    peek(ADDR_MODE, v); chk("R1 mode", v, 16'h0);
    peek(ADDR_DIR, v);  chk("R1 direction", v, 16'h0);
    for (int i = 0; i < 4; i++) begin
      peek(ADDR_CAP0 + i, v); chk("R1 capture", v, 16'h0);
    end
    chk("R1 irq", {15'd0, irqOut}, 16'd0);

    // ch0 rising, ch1 falling, ch2 both, ch3 off
    wrReg(ADDR_EDGE, 16'h0039);
    edgeOn(0, 1'b1, "R4 ch0 rising");
    edgeNone(0, 1'b0, "R5 ch0 falling ignored");
    edgeNone(1, 1'b1, "R5 ch1 rising ignored");
    edgeOn(1, 1'b0, "R5 ch1 falling");
    edgeOn(2, 1'b1, "R5 ch2 both rising");
    edgeOn(2, 1'b0, "R5 ch2 both falling");
    edgeNone(3, 1'b1, "R5 ch3 off rising");
    edgeNone(3, 1'b0, "R5 ch3 off falling");

    // R8 flag clearing
    wrReg(ADDR_FLAG, 16'h0000);
    peek(ADDR_FLAG, v); chk("R8 write zero keeps flags", v, 16'h0007);
    wrReg(ADDR_FLAG, 16'h0001);
    peek(ADDR_FLAG, v); chk("R8 write one clears", v, 16'h0006);

    // R10 interrupt
    chk("R10 irq low without enable", {15'd0, irqOut}, 16'd0);
    wrReg(ADDR_IEN, 16'h0002);
    chk("R10 irq high flag1 enabled", {15'd0, irqOut}, 16'd1);
    wrReg(ADDR_FLAG, 16'h0002);
    chk("R10 irq low after clear", {15'd0, irqOut}, 16'd0);
    wrReg(ADDR_FLAG, 16'h000F);
    wrReg(ADDR_IEN, 16'h0000);

    // R6 mode blocks capture
    wrReg(ADDR_MODE, 16'h0001);
    edgeNone(0, 1'b1, "R6 mode blocks");
    wrReg(ADDR_MODE, 16'h0000);
    edgeNone(0, 1'b0, "R5 ch0 falling ignored");
    // R7 direction blocks capture
    wrReg(ADDR_DIR, 16'h0001);
    peek(ADDR_DIR, v); chk("R7 direction readback", v, 16'h0001);
    edgeNone(0, 1'b1, "R7 output pin blocks");
    wrReg(ADDR_DIR, 16'h0000);
    edgeNone(0, 1'b0, "R5 ch0 falling ignored");

    // R9 capture vs clear in the same cycle
    edgeOn(0, 1'b1, "R4 ch0 rising again");
    edgeNone(0, 1'b0, "R5 ch0 falling ignored");
    @(negedge clk);
    peek(ADDR_CNT, c);
    pinIn[0] = 1'b1;
    sbQ.push_back('{0, c + 16'd2, "R9 capture wins"});
    @(negedge clk);
    @(negedge clk);
    regAddr = 4'(ADDR_FLAG); regWrData = 16'h0001; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    ->evCheck;
    @(evDone);
    wrReg(ADDR_FLAG, 16'h0001);
    peek(ADDR_FLAG, v); chk("R8 clear alone", v, 16'h0000);

    // R2 prescaler divide by 4, restart on write
    wrReg(ADDR_PRE, 16'h0002);
    peek(ADDR_CNT, c);
    repeat (3) @(negedge clk);
    peek(ADDR_CNT, v); chk("R2 no step before 4 clocks", v, c);
    @(negedge clk);
    peek(ADDR_CNT, v); chk("R2 first step at 4 clocks", v, c + 16'd1);
    repeat (3) @(negedge clk);
    peek(ADDR_CNT, v); chk("R2 hold within period", v, c + 16'd1);
    @(negedge clk);
    peek(ADDR_CNT, v); chk("R2 second step", v, c + 16'd2);

    // R3 wrap
    wrReg(ADDR_PRE, 16'h0000);
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      peek(ADDR_CNT, v);
      if (v == 16'hFFFF) break;
    end
    chk("R3 reached top", v, 16'hFFFF);
    @(negedge clk);
    peek(ADDR_CNT, v); chk("R3 wrap to zero", v, 16'h0000);

    finishRun();
  end
endmodule